// File: doc/BRIEF.md
# Two-Device Chained ADC Frame Receiver

This block is the master side of a link to two delta-sigma converters connected in a daisy chain and run as frame-sync slaves. From its own clock it makes the bit clock and the frame sync that the converters consume, and it drives their start line. One serial data line carries both converters' words in each frame. The first half of the frame is the directly attached (left) device and the second half is the right device, shifted through the left one. The block gathers each frame and delivers the two samples and their status bytes with a one-cycle valid strobe.

Configuration comes from three live inputs: a bit-clock divide setting, a status-byte enable and a delayed-framing (I2S) select. Whenever the effective configuration changes, the block pulses start low so the converters restart cleanly. It then throws away the first frame captured after the restart. Only the rising edge of the frame sync marks a frame. The sync stays high for the first half of the frame's bits.

Top module: `adc_chain_rx`

## Requirements
- R1: The bit clock spends exactly D master-clock cycles in each level, where D is `div_sel` clamped to the range 1 to 16 (0 gives 1, anything above 16 gives 16), so the bit clock never runs faster than half the master clock.
- R2: A frame lasts 64 bit clocks with status enabled and 48 with status disabled. `fsync` changes only together with a bit-clock falling edge, rises at the start of bit 0 and is high for the first half of the frame's bits.
- R3: `sdata` is sampled on bit-clock rising edges. In left-justified mode, bits 0-23 of the frame are the left sample MSB first, bits 24-31 the left status byte MSB first, bits 32-55 the right sample and bits 56-63 the right status byte.
- R4: In I2S mode (status enabled, `i2s_sel` = 1) each field sits one bit later than in R3. Bit 0 is ignored, and the least significant bit of each status output reads 0.
- R5: With `status_en` = 0, bits 0-23 are the left sample and bits 24-47 the right sample, both status outputs read 0, and `i2s_sel` has no effect.
- R6: `valid` is a one-cycle pulse that rises with the bit-clock rising edge of the last bit of a frame. The data outputs carry that frame's values and hold them until the next pulse.
- R7: After any change of the effective configuration (clamped divide, status enable, I2S select gated by status enable), `start` goes low for 8 master-clock cycles. While it is low, `bclk` is parked high and `fsync` and `valid` stay low.
- R8: The first frame after `start` rises produces no `valid`, and every later complete frame produces exactly one.
- R9: A change of the raw inputs that leaves the effective configuration unchanged (e.g. `div_sel` 20 to 25, or toggling `i2s_sel` while status is disabled) does not restart the converters.
- R10: While reset is held, `start`, `fsync` and `valid` are low, `bclk` is high and the sample outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_sel | input | 5 | Bit-clock half-period in master-clock cycles (clamped 1 to 16) |
| status_en | input | 1 | 1: 32-bit device words with status byte; 0: 24-bit words |
| i2s_sel | input | 1 | 1: data delayed one bit after the frame edge (status enabled only) |
| sdata | input | 1 | Serial data from the chained converters |
| start | output | 1 | Converter start line |
| bclk | output | 1 | Bit clock to the converters |
| fsync | output | 1 | Frame sync to the converters |
| valid | output | 1 | One-cycle strobe: new frame on the data outputs |
| left_data | output | 24 | Left sample, two's complement |
| left_stat | output | 8 | Left status byte |
| right_data | output | 24 | Right sample, two's complement |
| right_stat | output | 8 | Right status byte |

## Verification
The assertions assume that the configuration inputs change only between master-clock edges and that `sdata` settles within half a bit clock of a bit-clock falling edge, as a converter clocked on that edge would deliver it. The bench models the chained converters behaviourally. It updates `sdata` only just after the bit clock falls and changes configuration a fraction of a cycle after a rising master-clock edge. Restarts land both between frames and inside a frame, so the assertions' view of start, sync and strobe is tested across interrupted frames as well as clean ones.

// File: rtl/adcc_pkg.sv
package adcc_pkg;

    parameter int unsigned DIV_W = 5;

    typedef enum logic {
        SEQ_HOLD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_e;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             stat_en;
        logic             i2s;
    } link_cfg_t;

endpackage

// File: rtl/adcc_clkgen.sv
module adcc_clkgen
    import adcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             bclk,
    output logic             rise_stb,
    output logic             fall_stb
);

    typedef struct packed {
        logic [DIV_W-1:0] ph;
        logic             bclk;
    } clk_st_t;

    clk_st_t st_d, st_q;
    logic    tick;

    always_comb begin
        st_d = st_q;
        tick = run && (st_q.ph == (half_div - DIV_W'(1)));
        if (!run) begin
            st_d.ph   = '0;
            st_d.bclk = 1'b1;
        end else if (tick) begin
            st_d.ph   = '0;
            st_d.bclk = ~st_q.bclk;
        end else begin
            st_d.ph   = st_q.ph + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= '0;
            st_q.bclk <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign bclk     = st_q.bclk;
    assign rise_stb = tick && !st_q.bclk;
    assign fall_stb = tick && st_q.bclk;

endmodule

// File: rtl/adcc_unpack.sv
module adcc_unpack #(
    parameter int unsigned DATA_W = 24,
    parameter int unsigned STAT_W = 8,
    localparam int unsigned WORD_W = DATA_W + STAT_W
) (
    input  logic [2*WORD_W-1:0] frame_bits,
    input  logic                stat_en,
    input  logic                i2s,
    output logic [DATA_W-1:0]   l_data,
    output logic [STAT_W-1:0]   l_stat,
    output logic [DATA_W-1:0]   r_data,
    output logic [STAT_W-1:0]   r_stat
);

    always_comb begin
        if (!stat_en) begin
            l_data = frame_bits[2*DATA_W-1 -: DATA_W];
            r_data = frame_bits[DATA_W-1:0];
            l_stat = '0;
            r_stat = '0;
        end else if (i2s) begin
            l_data = frame_bits[2*WORD_W-2 -: DATA_W];
            l_stat = {frame_bits[2*WORD_W-2-DATA_W -: STAT_W-1], 1'b0};
            r_data = frame_bits[WORD_W-2 -: DATA_W];
            r_stat = {frame_bits[STAT_W-2:0], 1'b0};
        end else begin
            l_data = frame_bits[2*WORD_W-1 -: DATA_W];
            l_stat = frame_bits[2*WORD_W-1-DATA_W -: STAT_W];
            r_data = frame_bits[WORD_W-1 -: DATA_W];
            r_stat = frame_bits[STAT_W-1:0];
        end
    end

endmodule

// File: rtl/adc_chain_rx.sv
module adc_chain_rx
    import adcc_pkg::*;
#(
    parameter int unsigned DATA_W    = 24,
    parameter int unsigned STAT_W    = 8,
    parameter int unsigned DIV_MAX   = 16,
    parameter int unsigned START_LOW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              status_en,
    input  logic              i2s_sel,
    input  logic              sdata,
    output logic              start,
    output logic              bclk,
    output logic              fsync,
    output logic              valid,
    output logic [DATA_W-1:0] left_data,
    output logic [STAT_W-1:0] left_stat,
    output logic [DATA_W-1:0] right_data,
    output logic [STAT_W-1:0] right_stat
);

    localparam int unsigned WORD_W      = DATA_W + STAT_W;
    localparam int unsigned FRAME_LONG  = 2 * WORD_W;
    localparam int unsigned FRAME_SHORT = 2 * DATA_W;
    localparam int unsigned CNT_W       = $clog2(FRAME_LONG);
    localparam int unsigned HOLD_W      = $clog2(START_LOW + 1);

    typedef struct packed {
        seq_e                  seq;
        logic [HOLD_W-1:0]     hold_cnt;
        link_cfg_t             cfg;
        logic [CNT_W-1:0]      bit_cnt;
        logic                  fsync;
        logic [FRAME_LONG-1:0] sh;
        logic                  discard;
        logic                  valid;
        logic [DATA_W-1:0]     l_data;
        logic [STAT_W-1:0]     l_stat;
        logic [DATA_W-1:0]     r_data;
        logic [STAT_W-1:0]     r_stat;
    } rx_st_t;

    rx_st_t                st_d, st_q;
    link_cfg_t             cfg_in;
    logic [CNT_W-1:0]      last_bit, half_bits, next_bit;
    logic [FRAME_LONG-1:0] sh_next;
    logic                  rise_stb, fall_stb;
    logic [DATA_W-1:0]     up_l_data, up_r_data;
    logic [STAT_W-1:0]     up_l_stat, up_r_stat;

    // effective configuration: clamped divide, I2S only with status words
    always_comb begin
        if (div_sel == '0) begin
            cfg_in.div = DIV_W'(1);
        end else if (div_sel > DIV_W'(DIV_MAX)) begin
            cfg_in.div = DIV_W'(DIV_MAX);
        end else begin
            cfg_in.div = div_sel;
        end
        cfg_in.stat_en = status_en;
        cfg_in.i2s     = i2s_sel & status_en;
    end

    adcc_clkgen u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (st_q.seq == SEQ_RUN),
        .half_div (st_q.cfg.div),
        .bclk     (bclk),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    assign sh_next = {st_q.sh[FRAME_LONG-2:0], sdata};

    adcc_unpack #(
        .DATA_W (DATA_W),
        .STAT_W (STAT_W)
    ) u_unpack (
        .frame_bits (sh_next),
        .stat_en    (st_q.cfg.stat_en),
        .i2s        (st_q.cfg.i2s),
        .l_data     (up_l_data),
        .l_stat     (up_l_stat),
        .r_data     (up_r_data),
        .r_stat     (up_r_stat)
    );

    always_comb begin
        last_bit  = st_q.cfg.stat_en ? CNT_W'(FRAME_LONG - 1) : CNT_W'(FRAME_SHORT - 1);
        half_bits = st_q.cfg.stat_en ? CNT_W'(WORD_W) : CNT_W'(DATA_W);
        next_bit  = (st_q.bit_cnt == last_bit) ? '0 : st_q.bit_cnt + CNT_W'(1);

        st_d       = st_q;
        st_d.valid = 1'b0;

        if (cfg_in != st_q.cfg) begin
            // restart the converters with the new settings
            st_d.seq      = SEQ_HOLD;
            st_d.hold_cnt = '0;
            st_d.cfg      = cfg_in;
            st_d.fsync    = 1'b0;
        end else if (st_q.seq == SEQ_HOLD) begin
            st_d.fsync   = 1'b0;
            st_d.bit_cnt = last_bit;
            st_d.discard = 1'b1;
            if (st_q.hold_cnt == HOLD_W'(START_LOW - 1)) begin
                st_d.seq = SEQ_RUN;
            end else begin
                st_d.hold_cnt = st_q.hold_cnt + HOLD_W'(1);
            end
        end else begin
            if (fall_stb) begin
                st_d.bit_cnt = next_bit;
                st_d.fsync   = (next_bit < half_bits);
            end
            if (rise_stb) begin
                st_d.sh = sh_next;
                if (st_q.bit_cnt == last_bit) begin
                    if (st_q.discard) begin
                        st_d.discard = 1'b0;
                    end else begin
                        st_d.valid  = 1'b1;
                        st_d.l_data = up_l_data;
                        st_d.l_stat = up_l_stat;
                        st_d.r_data = up_r_data;
                        st_d.r_stat = up_r_stat;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seq         <= SEQ_HOLD;
            st_q.hold_cnt    <= '0;
            st_q.cfg.div     <= DIV_W'(1);
            st_q.cfg.stat_en <= 1'b1;
            st_q.cfg.i2s     <= 1'b0;
            st_q.bit_cnt     <= '0;
            st_q.fsync       <= 1'b0;
            st_q.sh          <= '0;
            st_q.discard     <= 1'b1;
            st_q.valid       <= 1'b0;
            st_q.l_data      <= '0;
            st_q.l_stat      <= '0;
            st_q.r_data      <= '0;
            st_q.r_stat      <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign start      = (st_q.seq == SEQ_RUN);
    assign fsync      = st_q.fsync;
    assign valid      = st_q.valid;
    assign left_data  = st_q.l_data;
    assign left_stat  = st_q.l_stat;
    assign right_data = st_q.r_data;
    assign right_stat = st_q.r_stat;

endmodule

// File: rtl/adcc_chk.sv
module adcc_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic bclk,
    input logic fsync,
    input logic valid
);

    // R2
    fsync_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(fsync) && start) |-> $fell(bclk));

    // R6
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    // R6
    valid_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> bclk);

    // R7
    quiet_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |-> (!fsync && !valid));

    // R7
    bclk_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !$past(start)) |-> bclk);

endmodule

bind adc_chain_rx adcc_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .bclk  (bclk),
    .fsync (fsync),
    .valid (valid)
);

// File: tb/adc_chain_rx_tb.sv
module adc_chain_rx_tb;

    localparam int START_LOW = 8;
    localparam int WDOG      = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  div_sel = 5'd2;
    logic        status_en = 1'b1;
    logic        i2s_sel = 1'b0;
    logic        sdata = 1'b0;
    logic        start, bclk, fsync, valid;
    logic [23:0] left_data, right_data;
    logic [7:0]  left_stat, right_stat;

    always #5 clk = ~clk;

    adc_chain_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_sel    (div_sel),
        .status_en  (status_en),
        .i2s_sel    (i2s_sel),
        .sdata      (sdata),
        .start      (start),
        .bclk       (bclk),
        .fsync      (fsync),
        .valid      (valid),
        .left_data  (left_data),
        .left_stat  (left_stat),
        .right_data (right_data),
        .right_stat (right_stat)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    typedef struct {
        logic [23:0] l;
        logic [23:0] r;
        logic [7:0]  ls;
        logic [7:0]  rs;
    } exp_t;

    exp_t exp_q[$];

    // model state
    int          m_div = 1;
    bit          m_stat = 1'b1;
    bit          m_i2s = 1'b0;
    bit          prev_start = 1'b0, prev_bclk = 1'b1, prev_fsync = 1'b0;
    int          low_len = 0, seg = 0, pos = 0, fi = 0;
    bit          seg_ok = 1'b0, pos_ok = 1'b0, hold_check = 1'b0;
    int          nvalid = 0, n_start_falls = 0;
    logic [63:0] cur = '0;
    bit          prev_last = 1'b0;
    int          cyc = 0;

    function automatic int eff_div(input logic [4:0] d);
        if (d == 0) return 1;
        if (d > 16) return 16;
        return int'(d);
    endfunction

    function automatic bit stream_bit(input int p);
        if (m_i2s) return (p == 0) ? prev_last : cur[64-p];
        return cur[63-p];
    endfunction

    // behavioural converter pair plus reference checks
    always @(negedge clk) begin
        if (rst_n) begin
            int flen;
            flen = m_stat ? 64 : 48;
            if (!start) begin
                if (prev_start) begin
                    // R8: at most the interrupted frame may still be pending
                    chk(exp_q.size() <= 1, "R8", "pending frames at restart", exp_q.size(), 1);
                    exp_q.delete();
                    n_start_falls++;
                end
                low_len++;
                fi = 0;
                seg_ok = 1'b0;
                pos_ok = 1'b0;
                if (valid) chk(1'b0, "R7", "valid while start low", 1, 0);
            end else begin
                if (!prev_start) begin
                    if (hold_check)
                        chk(low_len == START_LOW, "R7", "start low length", low_len, START_LOW);
                    hold_check = 1'b0;
                    low_len = 0;
                    seg = 1;
                    seg_ok = 1'b1;
                    m_div = eff_div(div_sel);
                    m_stat = status_en;
                    m_i2s = i2s_sel & status_en;
                    flen = m_stat ? 64 : 48;
                end else begin
                    if (bclk != prev_bclk) begin
                        if (seg_ok) chk(seg == m_div, "R1", "bclk half period", seg, m_div);
                        seg = 1;
                    end else begin
                        seg++;
                    end
                    if (fsync != prev_fsync)
                        chk(prev_bclk && !bclk, "R2", "fsync moved off a bclk fall", bclk, 0);
                    if (prev_bclk && !bclk) begin
                        if (fsync && !prev_fsync) begin
                            if (pos_ok) chk(pos == flen - 1, "R2", "frame length", pos + 1, flen);
                            pos = 0;
                            pos_ok = 1'b1;
                            fi++;
                            begin
                                exp_t e;
                                logic [23:0] ld, rd;
                                logic [7:0]  lsb, rsb;
                                prev_last = cur[0];
                                ld = 24'($urandom); rd = 24'($urandom);
                                lsb = 8'($urandom); rsb = 8'($urandom);
                                cur = m_stat ? {ld, lsb, rd, rsb} : {ld, rd, 16'h0};
                                e.l = ld;
                                e.r = rd;
                                if (!m_stat) begin
                                    e.ls = 8'h0; e.rs = 8'h0;
                                end else if (m_i2s) begin
                                    e.ls = {lsb[7:1], 1'b0}; e.rs = {rsb[7:1], 1'b0};
                                end else begin
                                    e.ls = lsb; e.rs = rsb;
                                end
                                if (fi >= 2) exp_q.push_back(e);
                            end
                        end else if (pos_ok) begin
                            pos++;
                            chk(fsync == (pos < flen / 2), "R2", "fsync level", fsync, pos < flen / 2);
                        end
                        if (pos_ok) sdata <= stream_bit(pos);
                    end
                end
                if (valid) begin
                    string tag;
                    nvalid++;
                    tag = !m_stat ? "R5" : (m_i2s ? "R4" : "R3");
                    chk(bclk && pos_ok && pos == flen - 1, "R6", "valid timing", pos, flen - 1);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R8", "valid for discarded frame", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(left_data == e.l, tag, "left sample", left_data, e.l);
                        chk(right_data == e.r, tag, "right sample", right_data, e.r);
                        chk(left_stat == e.ls, tag, "left status", left_stat, e.ls);
                        chk(right_stat == e.rs, tag, "right status", right_stat, e.rs);
                    end
                end
            end
            prev_start = start;
            prev_bclk = bclk;
            prev_fsync = fsync;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WDOG);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wait_valid(input int n);
        int target;
        target = nvalid + n;
        while (nvalid < target) @(negedge clk);
    endtask

    task automatic apply(input logic [4:0] d, input logic s, input logic i, input bit restart);
        @(posedge clk);
        #1;
        div_sel = d;
        status_en = s;
        i2s_sel = i;
        hold_check = restart;
    endtask

    initial begin
        int falls;
        // R10: reset state
        repeat (3) @(negedge clk);
        chk(start == 1'b0, "R10", "start in reset", start, 0);
        chk(bclk == 1'b1, "R10", "bclk in reset", bclk, 1);
        chk(fsync == 1'b0, "R10", "fsync in reset", fsync, 0);
        chk(valid == 1'b0, "R10", "valid in reset", valid, 0);
        chk(left_data == 24'h0 && right_data == 24'h0, "R10", "samples in reset", left_data, 0);
        @(posedge clk);
        #1 rst_n = 1'b1;

        // R3: left-justified 32-bit words, divide 2
        wait_valid(4);

        // R4 and R1 clamp of 0: delayed framing, divide 1
        apply(5'd0, 1'b1, 1'b1, 1'b1);
        wait_valid(4);

        // R5: 24-bit words, I2S request ignored
        apply(5'd3, 1'b0, 1'b1, 1'b1);
        wait_valid(4);

        // R9: I2S toggled while status disabled
        falls = n_start_falls;
        apply(5'd3, 1'b0, 1'b0, 1'b0);
        wait_valid(2);
        chk(n_start_falls == falls, "R9", "restart on i2s toggle", n_start_falls, falls);

        // R7 and R8: restart interrupted inside the discarded frame
        apply(5'd1, 1'b1, 1'b0, 1'b1);
        repeat (100) @(negedge clk);
        apply(5'd2, 1'b1, 1'b1, 1'b1);
        wait_valid(3);

        // R1: divide above the limit clamps to 16
        apply(5'd20, 1'b1, 1'b0, 1'b1);
        wait_valid(2);

        // R9: another out-of-range divide maps to the same value
        falls = n_start_falls;
        apply(5'd25, 1'b1, 1'b0, 1'b0);
        wait_valid(2);
        chk(n_start_falls == falls, "R9", "restart on clamped divide", n_start_falls, falls);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule